// File: doc/BRIEF.md
# Frame-Synchronous Shadow Register Commit Unit

This block keeps a display pipeline's configuration registers consistent across frames. Software-side logic loads a short list of pending updates into an entry queue. Each entry names a target register, carries a keep-mask and carries a value to merge in. A commit strobe then releases the list. A plain commit is held back until the timing generator reports the end of a frame, so a frame never starts with only part of a configuration in place. A full-mode commit, used when the whole timing is being rebuilt anyway, takes effect at once.

An interrupt status and enable section sits next to the register file. It records vsync, frame-done and underflow pulses. The frame-done enable is owned by the commit logic: a plain commit arms it, and it disarms itself once the queued writes have landed. A completion event fires on vsync, but only after a commit has been requested and no update is still waiting for its frame boundary.

Top module: `frame_commit_unit`

## Requirements
- R1: An applied entry updates its target register to `(old & mask) | value`. A mask of all zeros therefore replaces the register outright.
- R2: On commit, entries are applied in the order they were written. Processing stops at the first entry whose index is all ones (15 with the default 4-bit index). Entries after that terminator are not applied. Entries whose index is at or above the register count change nothing.
- R3: A plain commit (`commit` high, `commit_full` low) raises `pending_o` and arms the frame-done interrupt enable. The registers keep their values until a `frame_done` pulse is sampled while the commit is pending.
- R4: The queued writes become visible in the cycle after that `frame_done` is sampled, and `pending_o` clears in the same cycle. The frame-done enable turns itself off one cycle later. As a result, `irq_o` is high for exactly one cycle on account of that frame-done.
- R5: After any commit, `done_evt_o` pulses for one cycle in the cycle after a sampled `vsync`, provided `pending_o` was low when that `vsync` was sampled. A `vsync` seen while an update is pending produces no event.
- R6: When an interrupt enable goes from off to on while its status bit is already set, that stale status bit is cleared. For vsync the enable is `vsync_irq_en`; for frame-done the enable is armed by a plain commit.
- R7: `irq_status_o` bit 0 records vsync, bit 1 records frame-done and bit 2 records underflow. `irq_o` is high when bit 0 is set with the vsync enable on, or bit 1 is set with the frame-done enable on. Underflow is recorded in bit 2 but never raises `irq_o`.
- R8: A full-mode commit (`commit` and `commit_full` both high) applies the queue so that the result is visible in the next cycle, without waiting for frame-done.
- R9: The queue holds 16 entries. A write to a full queue is dropped and sets `overflow_o`, which then stays set until reset. Each apply empties the queue.
- R10: After reset, all registers, status bits, `pending_o`, `irq_o`, `done_evt_o` and `overflow_o` are zero.
- R11: `irq_ack` clears the status bits at the positions where it has ones. If a source pulses in the same cycle as its acknowledge, the set takes priority.

Ports are listed in port-list order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ent_wr | input | 1 | Load one queue entry |
| ent_idx | input | 4 | Target register index; all ones marks the terminator |
| ent_mask | input | 16 | Keep-mask of the entry |
| ent_val | input | 16 | Value ORed into the target register |
| commit | input | 1 | Commit strobe |
| commit_full | input | 1 | Qualifies `commit` as a full mode change |
| frame_done | input | 1 | End-of-frame pulse from the timing generator |
| vsync | input | 1 | Vertical sync pulse from the timing generator |
| underflow | input | 1 | Pixel fetch underflow pulse |
| vsync_irq_en | input | 1 | Vsync interrupt enable |
| irq_ack | input | 3 | Per-bit status clear |
| regs_o | output | 128 | Live registers, register n at bits [16n+15:16n] |
| irq_o | output | 1 | Interrupt request |
| irq_status_o | output | 3 | Status bits: vsync, frame-done, underflow |
| pending_o | output | 1 | A plain commit is waiting for frame-done |
| done_evt_o | output | 1 | One-cycle completion event |
| overflow_o | output | 1 | Sticky queue-overflow flag |

## Verification
The assertions assume a few things about the inputs. A plain and a full commit are never requested together with `frame_done` or with a queue write in the same cycle. No entry is loaded in a cycle in which the queue is being applied. The register count stays below the terminator index.

The stimulus follows these assumptions:
- Every strobe is driven for a single cycle, between clock edges.
- Commits, frame-done pulses and entry loads are issued in separate cycles.
- Vsync is issued both while a commit is pending and after it has completed, so that the held-off event and the released event are both exercised.

// File: rtl/fcu_pkg.sv
package fcu_pkg;
  localparam int unsigned ST_VS = 0;
  localparam int unsigned ST_FD = 1;
  localparam int unsigned ST_UF = 2;
  localparam int unsigned ST_W  = 3;
endpackage

// File: rtl/fcu_entry_queue.sv
module fcu_entry_queue #(
  parameter int unsigned DEPTH = 16,
  parameter int unsigned IW    = 4,
  parameter int unsigned DW    = 16,
  localparam int unsigned CW   = $clog2(DEPTH + 1)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                wr,
  input  logic [IW-1:0]       wr_idx,
  input  logic [DW-1:0]       wr_mask,
  input  logic [DW-1:0]       wr_val,
  input  logic                clear,
  output logic [DEPTH*IW-1:0] idx_flat,
  output logic [DEPTH*DW-1:0] mask_flat,
  output logic [DEPTH*DW-1:0] val_flat,
  output logic [CW-1:0]       count,
  output logic                overflow
);
  logic [IW-1:0] idx_q  [DEPTH];
  logic [DW-1:0] mask_q [DEPTH];
  logic [DW-1:0] val_q  [DEPTH];
  logic [CW-1:0] cnt_q, cnt_d;
  logic          ovf_q, ovf_d;
  logic          full, accept;

  assign full   = (cnt_q == CW'(DEPTH));
  assign accept = wr && !full && !clear;

  always_comb begin
    cnt_d = cnt_q;
    ovf_d = ovf_q;
    if (clear)       cnt_d = '0;
    else if (accept) cnt_d = cnt_q + 1'b1;
    if (wr && full)  ovf_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      ovf_q <= 1'b0;
    end else begin
      cnt_q <= cnt_d;
      ovf_q <= ovf_d;
    end
  end

  for (genvar e = 0; e < DEPTH; e++) begin : g_slot
    logic slot_we;
    assign slot_we = accept && (cnt_q == CW'(e));
    always_ff @(posedge clk) begin
      if (slot_we) begin
        idx_q[e]  <= wr_idx;
        mask_q[e] <= wr_mask;
        val_q[e]  <= wr_val;
      end
    end
    assign idx_flat[e*IW +: IW]  = idx_q[e];
    assign mask_flat[e*DW +: DW] = mask_q[e];
    assign val_flat[e*DW +: DW]  = val_q[e];
  end

  assign count    = cnt_q;
  assign overflow = ovf_q;

  assert_overflow_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
    ovf_q |=> ovf_q);
  assert_count_bound_R9: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= CW'(DEPTH));
  assert_clear_empties_R9: assert property (@(posedge clk) disable iff (!rst_n)
    clear |=> (cnt_q == '0));
endmodule

// File: rtl/fcu_apply.sv
module fcu_apply #(
  parameter int unsigned DEPTH = 16,
  parameter int unsigned IW    = 4,
  parameter int unsigned DW    = 16,
  parameter int unsigned NREGS = 8,
  localparam int unsigned CW   = $clog2(DEPTH + 1)
) (
  input  logic [NREGS*DW-1:0] cur_flat,
  input  logic [DEPTH*IW-1:0] idx_flat,
  input  logic [DEPTH*DW-1:0] mask_flat,
  input  logic [DEPTH*DW-1:0] val_flat,
  input  logic [CW-1:0]       count,
  output logic [NREGS*DW-1:0] nxt_flat
);
  localparam logic [IW-1:0] TERM = '1;

  always_comb begin
    logic stop;
    nxt_flat = cur_flat;
    stop     = 1'b0;
    for (int e = 0; e < DEPTH; e++) begin
      if (!stop && (CW'(e) < count)) begin
        if (idx_flat[e*IW +: IW] == TERM) begin
          stop = 1'b1;
        end else begin
          for (int r = 0; r < NREGS; r++) begin
            if (idx_flat[e*IW +: IW] == IW'(r))
              nxt_flat[r*DW +: DW] = (nxt_flat[r*DW +: DW] & mask_flat[e*DW +: DW])
                                     | val_flat[e*DW +: DW];
          end
        end
      end
    end
  end
endmodule

// File: rtl/fcu_irq.sv
module fcu_irq
  import fcu_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic            vsync,
  input  logic            frame_done,
  input  logic            underflow,
  input  logic            vs_en,
  input  logic            fd_en,
  input  logic            fd_en_rise,
  input  logic [ST_W-1:0] ack,
  output logic [ST_W-1:0] status,
  output logic            irq
);
  logic [ST_W-1:0] st_q, st_d, set_v, clr_v;
  logic            vs_en_q;
  logic            vs_rise;

  assign vs_rise = vs_en && !vs_en_q;

  always_comb begin
    set_v        = '0;
    set_v[ST_VS] = vsync;
    set_v[ST_FD] = frame_done;
    set_v[ST_UF] = underflow;
    clr_v        = ack;
    clr_v[ST_VS] = ack[ST_VS] | vs_rise;
    clr_v[ST_FD] = ack[ST_FD] | fd_en_rise;
    st_d         = set_v | (st_q & ~clr_v);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q    <= '0;
      vs_en_q <= 1'b0;
    end else begin
      st_q    <= st_d;
      vs_en_q <= vs_en;
    end
  end

  assign status = st_q;
  assign irq    = (st_q[ST_VS] && vs_en_q) || (st_q[ST_FD] && fd_en);

  assert_stale_vs_cleared_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (vs_en && !vs_en_q && !vsync) |=> !st_q[ST_VS]);
  assert_underflow_silent_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q[ST_VS] == 1'b0 && st_q[ST_FD] == 1'b0) |-> !irq);
  assert_set_wins_R11: assert property (@(posedge clk) disable iff (!rst_n)
    underflow |=> st_q[ST_UF]);
endmodule

// File: rtl/frame_commit_unit.sv
module frame_commit_unit
  import fcu_pkg::*;
#(
  parameter int unsigned DEPTH = 16,
  parameter int unsigned IW    = 4,
  parameter int unsigned DW    = 16,
  parameter int unsigned NREGS = 8
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                ent_wr,
  input  logic [IW-1:0]       ent_idx,
  input  logic [DW-1:0]       ent_mask,
  input  logic [DW-1:0]       ent_val,
  input  logic                commit,
  input  logic                commit_full,
  input  logic                frame_done,
  input  logic                vsync,
  input  logic                underflow,
  input  logic                vsync_irq_en,
  input  logic [ST_W-1:0]     irq_ack,
  output logic [NREGS*DW-1:0] regs_o,
  output logic                irq_o,
  output logic [ST_W-1:0]     irq_status_o,
  output logic                pending_o,
  output logic                done_evt_o,
  output logic                overflow_o
);
  localparam int unsigned CW = $clog2(DEPTH + 1);

  logic [DEPTH*IW-1:0] q_idx;
  logic [DEPTH*DW-1:0] q_mask, q_val;
  logic [CW-1:0]       q_cnt;
  logic [NREGS*DW-1:0] regs_q, regs_nxt;

  logic pend_q, pend_d, fden_q, fden_d, disarm_q, armed_q, armed_d, evt_q;
  logic apply_fd, apply_full, do_apply, commit_nf, fire, fd_rise;

  assign apply_fd   = frame_done && pend_q && fden_q;
  assign apply_full = commit && commit_full;
  assign do_apply   = apply_fd || apply_full;
  assign commit_nf  = commit && !commit_full;
  assign fire       = vsync && armed_q && !pend_q;
  assign fd_rise    = commit_nf && !fden_q;

  fcu_entry_queue #(.DEPTH(DEPTH), .IW(IW), .DW(DW)) u_queue (
    .clk(clk), .rst_n(rst_n), .wr(ent_wr), .wr_idx(ent_idx), .wr_mask(ent_mask),
    .wr_val(ent_val), .clear(do_apply), .idx_flat(q_idx), .mask_flat(q_mask),
    .val_flat(q_val), .count(q_cnt), .overflow(overflow_o));

  fcu_apply #(.DEPTH(DEPTH), .IW(IW), .DW(DW), .NREGS(NREGS)) u_apply (
    .cur_flat(regs_q), .idx_flat(q_idx), .mask_flat(q_mask), .val_flat(q_val),
    .count(q_cnt), .nxt_flat(regs_nxt));

  fcu_irq u_irq (
    .clk(clk), .rst_n(rst_n), .vsync(vsync), .frame_done(frame_done),
    .underflow(underflow), .vs_en(vsync_irq_en), .fd_en(fden_q), .fd_en_rise(fd_rise),
    .ack(irq_ack), .status(irq_status_o), .irq(irq_o));

  always_comb begin
    pend_d  = pend_q;
    fden_d  = fden_q;
    armed_d = armed_q;
    if (apply_fd)       pend_d = 1'b0;
    else if (commit_nf) pend_d = 1'b1;
    if (commit_nf)      fden_d = 1'b1;
    else if (disarm_q)  fden_d = 1'b0;
    if (commit)         armed_d = 1'b1;
    else if (fire)      armed_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q   <= 1'b0;
      fden_q   <= 1'b0;
      disarm_q <= 1'b0;
      armed_q  <= 1'b0;
      evt_q    <= 1'b0;
      regs_q   <= '0;
    end else begin
      pend_q   <= pend_d;
      fden_q   <= fden_d;
      disarm_q <= apply_fd;
      armed_q  <= armed_d;
      evt_q    <= fire;
      if (do_apply) regs_q <= regs_nxt;
    end
  end

  assign regs_o     = regs_q;
  assign pending_o  = pend_q;
  assign done_evt_o = evt_q;

  assert_hold_while_pending_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (pend_q && !frame_done && !apply_full) |=> $stable(regs_o));
  assert_pending_clears_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (apply_fd && !commit) |=> !pending_o);
  assert_evt_held_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (vsync && pend_q) |=> !done_evt_o);
  assert_full_no_pending_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (apply_full && !pend_q) |=> !pending_o);
endmodule

// File: tb/frame_commit_unit_tb.sv
module frame_commit_unit_tb_top;
  localparam int NR = 8;

  logic        clk, rst_n;
  logic        ent_wr, commit, commit_full, frame_done, vsync, underflow, vsync_irq_en;
  logic [3:0]  ent_idx;
  logic [15:0] ent_mask, ent_val;
  logic [2:0]  irq_ack;
  logic [NR*16-1:0] regs_o;
  logic        irq_o, pending_o, done_evt_o, overflow_o;
  logic [2:0]  irq_status_o;

  int n_chk = 0, n_fail = 0;
  bit done = 0;

  frame_commit_unit dut_i (
    .clk(clk), .rst_n(rst_n), .ent_wr(ent_wr), .ent_idx(ent_idx), .ent_mask(ent_mask),
    .ent_val(ent_val), .commit(commit), .commit_full(commit_full), .frame_done(frame_done),
    .vsync(vsync), .underflow(underflow), .vsync_irq_en(vsync_irq_en), .irq_ack(irq_ack),
    .regs_o(regs_o), .irq_o(irq_o), .irq_status_o(irq_status_o), .pending_o(pending_o),
    .done_evt_o(done_evt_o), .overflow_o(overflow_o));

  initial clk = 0;
  always #5 clk = ~clk;

  // behavioural reference model
  logic [15:0] m_reg [NR];
  int          q_i[$];
  logic [15:0] q_m[$], q_v[$];
  bit m_pend, m_fden, m_disarm, m_armed, m_evt, m_ovf, m_vsen;
  bit [2:0] m_st;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      foreach (m_reg[k]) m_reg[k] = 0;
      q_i.delete(); q_m.delete(); q_v.delete();
      m_pend = 0; m_fden = 0; m_disarm = 0; m_armed = 0; m_evt = 0; m_ovf = 0;
      m_vsen = 0; m_st = 0;
    end else begin
      bit ap_fd, ap_full, cnf, fire, vs_rise, fd_rise, o_disarm;
      bit [2:0] clr;
      ap_fd   = frame_done && m_pend && m_fden;
      ap_full = commit && commit_full;
      cnf     = commit && !commit_full;
      fire    = vsync && m_armed && !m_pend;
      vs_rise = vsync_irq_en && !m_vsen;
      fd_rise = cnf && !m_fden;
      o_disarm = m_disarm;
      if (ap_fd || ap_full) begin
        for (int e = 0; e < q_i.size(); e++) begin
          if (q_i[e] == 15) break;
          if (q_i[e] < NR) m_reg[q_i[e]] = (m_reg[q_i[e]] & q_m[e]) | q_v[e];
        end
        q_i.delete(); q_m.delete(); q_v.delete();
      end else if (ent_wr) begin
        if (q_i.size() == 16) m_ovf = 1;
        else begin q_i.push_back(int'(ent_idx)); q_m.push_back(ent_mask); q_v.push_back(ent_val); end
      end
      if (ap_fd) m_pend = 0; else if (cnf) m_pend = 1;
      if (cnf) m_fden = 1; else if (o_disarm) m_fden = 0;
      m_disarm = ap_fd;
      if (commit) m_armed = 1; else if (fire) m_armed = 0;
      m_evt = fire;
      clr = irq_ack | {1'b0, fd_rise, vs_rise};
      m_st = {underflow, frame_done, vsync} | (m_st & ~clr);
      m_vsen = vsync_irq_en;
    end
  end

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  always @(negedge clk) if (rst_n && !done) begin
    for (int r = 0; r < NR; r++)
      chk(regs_o[r*16 +: 16] == m_reg[r], "R1/R2 register", regs_o[r*16 +: 16], m_reg[r]);
    chk(pending_o == m_pend, "R3 pending", pending_o, m_pend);
    chk(irq_o == ((m_st[0] && m_vsen) || (m_st[1] && m_fden)), "R7 irq", irq_o,
        (m_st[0] && m_vsen) || (m_st[1] && m_fden));
    chk(irq_status_o == m_st, "R11 status", irq_status_o, m_st);
    chk(done_evt_o == m_evt, "R5 event", done_evt_o, m_evt);
    chk(overflow_o == m_ovf, "R9 overflow", overflow_o, m_ovf);
  end

  task automatic idle(); @(negedge clk); endtask
  task automatic wr(input logic [3:0] i, input logic [15:0] m, input logic [15:0] v);
    @(negedge clk); ent_wr = 1; ent_idx = i; ent_mask = m; ent_val = v;
    @(negedge clk); ent_wr = 0;
  endtask
  task automatic do_commit(input bit full);
    @(negedge clk); commit = 1; commit_full = full;
    @(negedge clk); commit = 0; commit_full = 0;
  endtask
  task automatic pulse_fd();
    @(negedge clk); frame_done = 1; @(negedge clk); frame_done = 0;
  endtask
  task automatic pulse_vs();
    @(negedge clk); vsync = 1; @(negedge clk); vsync = 0;
  endtask
  function automatic logic [15:0] rg(input int r); return regs_o[r*16 +: 16]; endfunction

  task automatic finish_run();
    done = 1;
    $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog actual=running expected=finished");
    finish_run();
  end

  initial begin
    rst_n = 0; ent_wr = 0; ent_idx = 0; ent_mask = 0; ent_val = 0; commit = 0;
    commit_full = 0; frame_done = 0; vsync = 0; underflow = 0; vsync_irq_en = 0; irq_ack = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R10 reset state
    chk(regs_o == '0 && !irq_o && irq_status_o == 0 && !pending_o && !done_evt_o && !overflow_o,
        "R10 reset", regs_o[31:0], 0);
    // R8 full commit, R1 zero mask overwrite
    wr(0, 16'h0000, 16'h1234); wr(1, 16'h0000, 16'hAAAA); wr(15, 0, 0);
    do_commit(1);
    chk(rg(0) == 16'h1234, "R8 full commit reg0", rg(0), 16'h1234);
    chk(rg(1) == 16'hAAAA, "R1 overwrite reg1", rg(1), 16'hAAAA);
    // R1 masked, R2 order and terminator, R3 hold
    wr(1, 16'hFF00, 16'h0055);
    wr(0, 16'h0000, 16'h0001); wr(0, 16'hFFFF, 16'h0100);
    wr(15, 0, 0); wr(2, 16'h0000, 16'h7777);
    do_commit(0);
    chk(pending_o, "R3 pending set", pending_o, 1);
    pulse_vs();
    chk(!done_evt_o, "R5 held while pending", done_evt_o, 0);
    repeat (3) idle();
    chk(rg(1) == 16'hAAAA, "R3 hold until frame-done", rg(1), 16'hAAAA);
    @(negedge clk); frame_done = 1; @(negedge clk); frame_done = 0;
    chk(rg(1) == 16'hAA55, "R1 masked merge", rg(1), 16'hAA55);
    chk(rg(0) == 16'h0101, "R2 in-order", rg(0), 16'h0101);
    chk(rg(2) == 16'h0000, "R2 terminator", rg(2), 0);
    chk(!pending_o && irq_o, "R4 pending clear, irq one cycle", {pending_o, irq_o}, 1);
    idle();
    chk(!irq_o, "R4 frame-done enable disarmed", irq_o, 0);
    pulse_vs();
    chk(done_evt_o, "R5 event after commit", done_evt_o, 1);
    idle();
    chk(!done_evt_o, "R5 single pulse", done_evt_o, 0);
    // R11 ack, R6 stale frame-done
    @(negedge clk); irq_ack = 3'b010; @(negedge clk); irq_ack = 0;
    chk(irq_status_o[1] == 0, "R11 ack clears", irq_status_o, 0);
    pulse_fd();
    chk(irq_status_o[1] && !irq_o, "R6 fd status unarmed", irq_status_o, 2);
    wr(9, 16'h0000, 16'hBEEF);
    do_commit(0);
    chk(irq_status_o[1] == 0 && !irq_o, "R6 stale fd cleared", irq_status_o, 0);
    pulse_fd();
    chk(regs_o[127:0] == {16'h0, 16'h0, 16'h0, 16'h0, 16'h0, 16'h0, 16'hAA55, 16'h0101},
        "R2 out-of-range ignored", rg(2), 0);
    // R6 vsync stale, R7
    pulse_vs();
    @(negedge clk); vsync_irq_en = 1;
    idle();
    chk(irq_status_o[0] == 0 && !irq_o, "R6 stale vsync cleared", irq_status_o, 0);
    pulse_vs();
    chk(irq_o, "R7 vsync irq", irq_o, 1);
    @(negedge clk); irq_ack = 3'b001; vsync = 1; @(negedge clk); irq_ack = 0; vsync = 0;
    chk(irq_status_o[0], "R11 set wins over ack", irq_status_o, 1);
    @(negedge clk); irq_ack = 3'b111; @(negedge clk); irq_ack = 0;
    @(negedge clk); underflow = 1; @(negedge clk); underflow = 0;
    chk(irq_status_o == 3'b100 && !irq_o, "R7 underflow silent", {irq_status_o, irq_o}, 8);
    // R9 overflow
    for (int k = 0; k < 17; k++) wr(3, 16'h0000, 16'(k << 8));
    chk(overflow_o, "R9 overflow set", overflow_o, 1);
    do_commit(1);
    chk(rg(3) == 16'h0F00, "R9 17th dropped", rg(3), 16'h0F00);
    wr(4, 16'h0000, 16'h0042); do_commit(1);
    chk(rg(4) == 16'h0042 && overflow_o, "R9 queue emptied, flag sticky", rg(4), 16'h0042);
    repeat (3) idle();
    finish_run();
  end
endmodule